// File: doc/BRIEF.md
# Selectable-Source Two-Stage Clock Divider

This cell derives one clock-enable strobe from a choice of several source strobes, all inside a single fast reference clock domain. A 16-bit control word picks an oscillator strobe or one of three PLL strobes. On instances built with it, an override bit substitutes an alternate oscillator strobe. The chosen strobe is counted down by a first divider and then by a second, cascaded divider. A disable bit masks the result entirely.

Software-style access is a single write port and a read port. The read port returns the stored control word with every unimplemented bit forced to zero. Each instance fixes three things by parameter: whether the second divider exists, whether the alternate-oscillator override exists, and whether the spare bit 14 can be written. It also fixes how many bits of each divider field are implemented. Any write restarts both divider counters. The output strobe is registered and follows the qualifying source strobe by one cycle.

Top module: `srcdiv_cell`

## Requirements
- R1: While bit 15 (disable) of the stored word is 1, `out_stb` stays 0. Reset leaves this bit at 1.
- R2: Bits 13:12 pick the source strobe: 0 is `osc_stb`, 1 is `pll0_stb`, 2 is `pll1_stb`, 3 is `pll2_stb`.
- R3: On an instance with the override, bit 11 = 1 selects `alt_osc_stb` and bits 13:12 are then ignored. On an instance without it, bit 11 reads 0 and has no effect.
- R4: Bits 3:0 hold the first divisor field D1. The first stage passes every (D1+1)-th selected strobe.
- R5: On an instance with the second stage, bits 7:4 hold D2. `out_stb` pulses for one cycle, one cycle after every ((D1+1)*(D2+1))-th selected strobe counted since the last restart.
- R6: Bit 14 stores the written value only on instances built with a writable spare bit. Otherwise it reads 0.
- R7: Features an instance lacks read back as 0 and have no effect on the output. These are the second-stage field (bits 7:4), the override bit, and the D1 bits above the implemented width.
- R8: After reset the read port returns 0x8000. From the cycle after a write it returns the written word with unimplemented bits cleared. Bits 10:8 always read 0.
- R9: A write clears both divider counters. A source strobe arriving in the same cycle as the write is not counted, and no output pulse follows that cycle.
- R10: When a write clears the disable bit, the first output pulse needs a full (D1+1)*(D2+1) selected strobes after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to store |
| rd_data | output | 16 | Stored control word, unimplemented bits zero |
| osc_stb | input | 1 | Oscillator source strobe (select 0) |
| pll0_stb | input | 1 | PLL0 source strobe (select 1) |
| pll1_stb | input | 1 | PLL1 source strobe (select 2) |
| pll2_stb | input | 1 | PLL2 source strobe (select 3) |
| alt_osc_stb | input | 1 | Alternate oscillator strobe (override) |
| out_stb | output | 1 | Divided output strobe |

## Verification
The assertions assume that every source input is already a one-cycle-wide strobe in the reference domain. They also assume that writes are plain single-cycle pulses whose data is stable in that cycle. Nothing is assumed about how close together strobes or writes arrive.

The stimulus respects these assumptions by driving every input at the falling edge. Each source bit is drawn independently every cycle, at densities that range up to a strobe on every cycle. Random writes land anywhere, including mid-count and in the same cycle as a source strobe, so the counter restart and the dropped strobe are both exercised.

// File: rtl/srcdiv_pkg.sv
package srcdiv_pkg;

   localparam int unsigned CW         = 16;
   localparam int unsigned FIELD_W    = 4;
   localparam int unsigned BIT_OFF    = 15;
   localparam int unsigned BIT_SPARE  = 14;
   localparam int unsigned SEL_LSB    = 12;
   localparam int unsigned BIT_ALT    = 11;
   localparam int unsigned D2_LSB     = 4;
   localparam int unsigned D1_LSB     = 0;
   localparam logic [CW-1:0] RST_WORD = 16'h8000;

   typedef enum logic [1:0] {
      SRC_OSC  = 2'd0,
      SRC_PLL0 = 2'd1,
      SRC_PLL1 = 2'd2,
      SRC_PLL2 = 2'd3
   } src_sel_e;

   // bits of the control word that an instance actually stores
   function automatic logic [CW-1:0] live_mask(input bit has_d2, input bit has_alt,
                                               input bit has_spare,
                                               input int unsigned d1w,
                                               input int unsigned d2w);
      logic [CW-1:0] m;
      m = '0;
      m[BIT_OFF]              = 1'b1;
      m[SEL_LSB +: 2]         = 2'b11;
      m[BIT_SPARE]            = has_spare;
      m[BIT_ALT]              = has_alt;
      for (int i = 0; i < int'(FIELD_W); i++) begin
         m[D1_LSB + i] = (i < int'(d1w));
         m[D2_LSB + i] = has_d2 && (i < int'(d2w));
      end
      return m;
   endfunction

endpackage

// File: rtl/srcdiv_ctrl_reg.sv
module srcdiv_ctrl_reg
   import srcdiv_pkg::*;
#(
   parameter logic [CW-1:0] MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] ctrl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= RST_WORD & MASK;
      end else if (wr_en) begin
         ctrl_q <= wr_data & MASK;
      end
   end

endmodule

// File: rtl/srcdiv_src_mux.sv
module srcdiv_src_mux
   import srcdiv_pkg::*;
(
   input  src_sel_e sel,
   input  logic     alt_en,
   input  logic     osc_stb,
   input  logic     pll0_stb,
   input  logic     pll1_stb,
   input  logic     pll2_stb,
   input  logic     alt_osc_stb,
   output logic     src_stb
);

   logic base_stb;

   always_comb begin
      unique case (sel)
         SRC_OSC:  base_stb = osc_stb;
         SRC_PLL0: base_stb = pll0_stb;
         SRC_PLL1: base_stb = pll1_stb;
         SRC_PLL2: base_stb = pll2_stb;
         default:  base_stb = 1'b0;
      endcase
   end

   // override wins over the select field
   assign src_stb = alt_en ? alt_osc_stb : base_stb;

endmodule

// File: rtl/srcdiv_stage.sv
module srcdiv_stage #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick_in,
   input  logic [W-1:0] limit,
   output logic         tick_out
);

   logic [W-1:0] cnt_q;
   logic         at_limit;

   assign at_limit = (cnt_q == limit);
   assign tick_out = tick_in && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick_in) begin
         cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/srcdiv_cell.sv
module srcdiv_cell
   import srcdiv_pkg::*;
#(
   parameter bit          HAS_DIV2  = 1'b1,
   parameter bit          HAS_ALT   = 1'b1,
   parameter bit          HAS_SPARE = 1'b0,
   parameter int unsigned DIV1_W    = 4,
   parameter int unsigned DIV2_W    = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   output logic [15:0] rd_data,
   input  logic        osc_stb,
   input  logic        pll0_stb,
   input  logic        pll1_stb,
   input  logic        pll2_stb,
   input  logic        alt_osc_stb,
   output logic        out_stb
);

   localparam logic [CW-1:0] MASK =
      live_mask(HAS_DIV2, HAS_ALT, HAS_SPARE, DIV1_W, DIV2_W);

   if (DIV1_W < 1 || DIV1_W > FIELD_W) begin : g_bad_d1
      $error("srcdiv_cell: DIV1_W must lie in 1..4");
   end
   if (DIV2_W < 1 || DIV2_W > FIELD_W) begin : g_bad_d2
      $error("srcdiv_cell: DIV2_W must lie in 1..4");
   end

   logic [CW-1:0] ctrl_q;
   logic          off;
   logic          clr;
   logic          src_stb;
   logic          s1_stb;
   logic          s2_stb;
   src_sel_e      sel;

   srcdiv_ctrl_reg #(.MASK(MASK)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ctrl_q  (ctrl_q)
   );

   assign rd_data = ctrl_q;
   assign off     = ctrl_q[BIT_OFF];
   assign clr     = wr_en || off;
   assign sel     = src_sel_e'(ctrl_q[SEL_LSB +: 2]);

   srcdiv_src_mux u_mux (
      .sel         (sel),
      .alt_en      (ctrl_q[BIT_ALT]),
      .osc_stb     (osc_stb),
      .pll0_stb    (pll0_stb),
      .pll1_stb    (pll1_stb),
      .pll2_stb    (pll2_stb),
      .alt_osc_stb (alt_osc_stb),
      .src_stb     (src_stb)
   );

   srcdiv_stage #(.W(DIV1_W)) u_stage1 (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .tick_in  (src_stb),
      .limit    (ctrl_q[D1_LSB +: DIV1_W]),
      .tick_out (s1_stb)
   );

   if (HAS_DIV2) begin : g_stage2
      srcdiv_stage #(.W(DIV2_W)) u_stage2 (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .tick_in  (s1_stb),
         .limit    (ctrl_q[D2_LSB +: DIV2_W]),
         .tick_out (s2_stb)
      );
   end else begin : g_bypass2
      assign s2_stb = s1_stb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_stb <= 1'b0;
      end else begin
         out_stb <= s2_stb && !clr;
      end
   end

endmodule

// File: rtl/srcdiv_cell_chk.sv
module srcdiv_cell_chk
   import srcdiv_pkg::*;
#(
   parameter bit          HAS_DIV2  = 1'b1,
   parameter bit          HAS_ALT   = 1'b1,
   parameter bit          HAS_SPARE = 1'b0,
   parameter int unsigned DIV1_W    = 4,
   parameter int unsigned DIV2_W    = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [15:0] wr_data,
   input logic [15:0] rd_data,
   input logic        osc_stb,
   input logic        pll0_stb,
   input logic        pll1_stb,
   input logic        pll2_stb,
   input logic        alt_osc_stb,
   input logic        out_stb
);

   localparam logic [CW-1:0] MASK =
      live_mask(HAS_DIV2, HAS_ALT, HAS_SPARE, DIV1_W, DIV2_W);

   // R1
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BIT_OFF] |=> !out_stb);

   // R9
   wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !out_stb);

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(osc_stb || pll0_stb || pll1_stb || pll2_stb || alt_osc_stb) |=> !out_stb);

   // R8
   rdback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == ($past(wr_data) & MASK)));

   // R8
   resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[10:8] == 3'b000);

   if (!HAS_DIV2) begin : g_no_d2
      // R7
      no_div2_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_data[D2_LSB +: FIELD_W] == '0);
   end

   if (!HAS_SPARE) begin : g_no_spare
      // R6
      spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_data[BIT_SPARE]);
   end

endmodule

bind srcdiv_cell srcdiv_cell_chk #(
   .HAS_DIV2  (HAS_DIV2),
   .HAS_ALT   (HAS_ALT),
   .HAS_SPARE (HAS_SPARE),
   .DIV1_W    (DIV1_W),
   .DIV2_W    (DIV2_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .osc_stb     (osc_stb),
   .pll0_stb    (pll0_stb),
   .pll1_stb    (pll1_stb),
   .pll2_stb    (pll2_stb),
   .alt_osc_stb (alt_osc_stb),
   .out_stb     (out_stb)
);

// File: tb/srcdiv_cell_bench.sv
module srcdiv_cell_bench;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        osc = 1'b0, pll0 = 1'b0, pll1 = 1'b0, pll2 = 1'b0, alt = 1'b0;
   wire  [15:0] rd_a, rd_b;
   wire         out_a, out_b;

   // full-featured instance
   srcdiv_cell u_srcdiv_cell (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a),
      .osc_stb(osc), .pll0_stb(pll0), .pll1_stb(pll1), .pll2_stb(pll2),
      .alt_osc_stb(alt), .out_stb(out_a));

   // reduced instance: no second stage, no override, spare writable, 3-bit D1
   srcdiv_cell #(.HAS_DIV2(1'b0), .HAS_ALT(1'b0), .HAS_SPARE(1'b1), .DIV1_W(3))
      u_srcdiv_cell_lite (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
      .osc_stb(osc), .pll0_stb(pll0), .pll1_stb(pll1), .pll2_stb(pll2),
      .alt_osc_stb(alt), .out_stb(out_b));

   int    total = 0;
   int    bad   = 0;
   bit    done  = 1'b0;
   string prev_tag = "R8";

   logic [15:0] m_cfg [2];
   int          m_cnt [2];
   logic        m_exp [2];

   // word as each instance should store it (R6, R7, R8)
   function automatic logic [15:0] eff(input int k, input logic [15:0] w);
      logic [15:0] r;
      r = '0;
      r[15]    = w[15];
      r[13:12] = w[13:12];
      if (k == 0) begin
         r[11]  = w[11];
         r[7:0] = w[7:0];
      end else begin
         r[14]  = w[14];
         r[2:0] = w[2:0];
      end
      return r;
   endfunction

   // s = {alt, pll2, pll1, pll0, osc} (R2, R3)
   function automatic logic pick(input logic [15:0] c, input logic [4:0] s);
      if (c[11]) return s[4];
      return s[c[13:12]];
   endfunction

   // output period in selected strobes (R4, R5)
   function automatic int period(input logic [15:0] c);
      return (int'(c[3:0]) + 1) * (int'(c[7:4]) + 1);
   endfunction

   function automatic logic [4:0] rnd_src(input int pct);
      logic [4:0] s;
      for (int i = 0; i < 5; i++) s[i] = (($urandom % 100) < pct);
      return s;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input logic w, input logic [15:0] d, input logic [4:0] s,
                       input string tag);
      @(negedge clk);
      chk(prev_tag, "out_a", {15'b0, out_a}, {15'b0, m_exp[0]});
      chk(prev_tag, "out_b", {15'b0, out_b}, {15'b0, m_exp[1]});
      chk(prev_tag, "rd_a", rd_a, m_cfg[0]);
      chk(prev_tag, "rd_b", rd_b, m_cfg[1]);
      wr_en = w; wr_data = d;
      {alt, pll2, pll1, pll0, osc} = s;
      for (int k = 0; k < 2; k++) begin
         m_exp[k] = 1'b0;
         if (w) begin
            m_cfg[k] = eff(k, d);
            m_cnt[k] = 0;
         end else if (!m_cfg[k][15] && pick(m_cfg[k], s)) begin
            m_cnt[k]++;
            if (m_cnt[k] == period(m_cfg[k])) begin
               m_exp[k] = 1'b1;
               m_cnt[k] = 0;
            end
         end
      end
      prev_tag = tag;
   endtask

   task automatic run(input int n, input int pct, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 16'h0, rnd_src(pct), tag);
   endtask

   task automatic wr(input logic [15:0] d, input string tag);
      step(1'b1, d, rnd_src(50), tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < 2; k++) begin
         m_cfg[k] = 16'h8000; m_cnt[k] = 0; m_exp[k] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 reset value, R1 quiet while disabled
      step(1'b0, 16'h0, 5'h1f, "R8");
      run(30, 60, "R1");
      // R4 first stage alone
      wr(16'h0000, "R4"); run(60, 50, "R4");
      wr(16'h0003, "R4"); run(80, 50, "R4");
      // R5 cascaded stages
      wr(16'h1025, "R5"); run(300, 60, "R5");
      // R2 other selects
      wr(16'h20F1, "R2"); run(400, 70, "R2");
      wr(16'h3012, "R2"); run(200, 50, "R2");
      // R3 override (lite ignores it, keeps pll2)
      wr(16'h3802, "R3"); run(150, 50, "R3");
      // R6 spare bit
      wr(16'h4000, "R6"); run(5, 50, "R6");
      // R7 unsupported fields, reserved bits
      wr(16'h07FF, "R7"); run(60, 90, "R7");
      // R1 disable with a short divisor
      wr(16'h8000, "R1"); run(40, 100, "R1");
      // R10 re-enable: every cycle strobes, first pulse after full period
      wr(16'h8012, "R10"); run(5, 100, "R10");
      wr(16'h0012, "R10"); run(14, 100, "R10");
      // R9 restart mid-count, strobe in the write cycle dropped
      wr(16'h0004, "R9"); run(3, 100, "R9");
      step(1'b1, 16'h0004, 5'h1f, "R9"); run(12, 100, "R9");
      // constrained random mix
      begin
         int pct = 50;
         for (int i = 0; i < 8000; i++) begin
            if (($urandom % 50) == 0) begin
               logic [15:0] d;
               d = 16'($urandom);
               if (($urandom % 8) != 0) d[15] = 1'b0;
               pct = 20 + int'($urandom % 81);
               step(1'b1, d, rnd_src(pct), "R9");
            end else begin
               step(1'b0, 16'h0, rnd_src(pct), "R5");
            end
         end
      end
      step(1'b0, 16'h0, 5'h0, "R5");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule